// File: doc/BRIEF.md
# Detection Flag Bitmap Updater

This block holds a map with one bit per detection cell. The map lives in a synchronous RAM. There is one word for each range bin, and bit k of that word holds the flag for Doppler bin k. A detector sends results as a stream. Each result carries a valid strobe, a hit flag, a range bin and a Doppler bin. For each accepted result the block runs a three-cycle read-modify-write. It reads the word, waits one cycle for the RAM, then writes the word back with the one addressed bit replaced.

The update path is not pipelined. A producer that sends at most one result every third cycle never loses a result. A result that arrives while the block is busy is dropped, and the block counts it. A host port can read any word. A clear request wipes the whole map, one word per cycle.

Top module: `det_map_rmw`

## Requirements
- R1: A valid result is accepted only when the block is idle and no clear is requested. `busy` is high in the two cycles after the accepting edge and low in the third, so the next result can be accepted in that third cycle.
- R2: A valid result that arrives while `busy` is high is dropped. The map word it addresses stays unchanged.
- R3: The map holds word r for range bin r. Bit k of that word is the flag for Doppler bin k, with bit 0 as the least significant bit.
- R4: Write-back replaces only the addressed bit with the incoming flag, writing 1 to set it or 0 to clear it. Every other bit of the word keeps its value.
- R5: A producer that sends one result every third cycle has every result applied and causes no drops.
- R6: Each dropped result increments a 16-bit drop counter, which saturates at 65535. Each drop also sets the sticky `drop_sticky` bit.
- R7: A host read is accepted when `rd_en` is high, the block is idle, and neither `in_valid` nor `clr_req` is high. `rd_valid` then pulses for one cycle, two cycles later, with the addressed word on `rd_data`.
- R8: A clear accepted in the idle state zeroes all 512 words and keeps `busy` high for 512 cycles. It clears `drop_sticky` and takes priority over a valid in the same cycle. Valids during the clear are dropped and counted.
- R9: An active-low asynchronous reset returns the block to idle at once, with `busy`, the drop counter, `drop_sticky` and `rd_valid` all at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Detection result strobe |
| in_flag | input | 1 | Detection hit flag |
| in_range | input | 9 | Range bin of the result |
| in_dop | input | 5 | Doppler bin of the result |
| clr_req | input | 1 | Request to clear the whole map |
| rd_en | input | 1 | Host read request |
| rd_addr | input | 9 | Host read word address (range bin) |
| rd_data | output | 32 | Host read word |
| rd_valid | output | 1 | Pulses when `rd_data` holds the requested word |
| busy | output | 1 | An update or a clear is in progress |
| drop_cnt | output | 16 | Saturating count of dropped results |
| drop_sticky | output | 1 | Set by any drop, cleared by a map clear |

## Verification
Each response has a fixed delay after its stimulus. `busy` rises in the first cycle after an accepted result and falls in the third. The written word can be read back once `busy` has fallen. A host read returns its data two cycles after the request. The drop counter and the sticky bit change in the cycle after the rejected valid. A clear holds `busy` for exactly 512 cycles.

The bench drives every input at a falling edge and samples at the following falling edges. Each check therefore counts whole cycles from the edge that took the stimulus and compares against these fixed offsets.

// File: rtl/det_map_rmw.sv
module det_map_rmw #(
  parameter int RANGE_W = 9,
  parameter int DOP_W   = 5,
  parameter int CNT_W   = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic                    in_flag,
  input  logic [RANGE_W-1:0]      in_range,
  input  logic [DOP_W-1:0]        in_dop,
  input  logic                    clr_req,
  input  logic                    rd_en,
  input  logic [RANGE_W-1:0]      rd_addr,
  output logic [(1<<DOP_W)-1:0]   rd_data,
  output logic                    rd_valid,
  output logic                    busy,
  output logic [CNT_W-1:0]        drop_cnt,
  output logic                    drop_sticky
);
  localparam int WORDS = 1 << RANGE_W;
  localparam int BITS  = 1 << DOP_W;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_WB, S_CLR} st_t;
  st_t st;

  logic [BITS-1:0]    mem [WORDS];
  logic [BITS-1:0]    q;
  logic [RANGE_W-1:0] r_rng, clr_idx;
  logic [DOP_W-1:0]   r_dop;
  logic               r_flag, rd_pend;

  wire idle     = (st == S_IDLE);
  wire take_clr = idle && clr_req;
  wire take_upd = idle && !clr_req && in_valid;
  wire take_rd  = idle && !clr_req && !in_valid && rd_en;
  wire drop     = in_valid && !take_upd;
  wire [RANGE_W-1:0] raddr = take_upd ? in_range : rd_addr;
  wire [BITS-1:0] bmask = BITS'(1) << r_dop;
  wire [BITS-1:0] wword = r_flag ? (q | bmask) : (q & ~bmask);

  assign busy = !idle;

  always_ff @(posedge clk) begin
    if (take_upd || take_rd) q <= mem[raddr];
    if (st == S_WB)       mem[r_rng]   <= wword;
    else if (st == S_CLR) mem[clr_idx] <= '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      r_rng       <= '0;
      r_dop       <= '0;
      r_flag      <= 1'b0;
      clr_idx     <= '0;
      rd_pend     <= 1'b0;
      rd_valid    <= 1'b0;
      rd_data     <= '0;
      drop_cnt    <= '0;
      drop_sticky <= 1'b0;
    end else begin
      rd_pend  <= take_rd;
      rd_valid <= rd_pend;
      if (rd_pend) rd_data <= q;
      case (st)
        S_IDLE: begin
          if (take_clr) begin
            st          <= S_CLR;
            clr_idx     <= '0;
            drop_sticky <= 1'b0;
          end else if (take_upd) begin
            st     <= S_WAIT;
            r_rng  <= in_range;
            r_dop  <= in_dop;
            r_flag <= in_flag;
          end
        end
        S_WAIT: st <= S_WB;
        S_WB:   st <= S_IDLE;
        S_CLR: begin
          clr_idx <= clr_idx + 1'b1;
          if (clr_idx == RANGE_W'(WORDS-1)) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
      if (drop) begin
        drop_sticky <= 1'b1;
        if (drop_cnt != {CNT_W{1'b1}}) drop_cnt <= drop_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/det_map_rmw_chk.sv
module det_map_rmw_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             clr_req,
  input logic             rd_en,
  input logic             busy,
  input logic             rd_valid,
  input logic [CNT_W-1:0] drop_cnt,
  input logic             drop_sticky
);
  a_r1_busy_seq: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && in_valid && !clr_req) |=> busy ##1 busy ##1 !busy);

  a_r2_drop_counted: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && in_valid) |=> ((drop_cnt != $past(drop_cnt)) || (&$past(drop_cnt))));

  a_r6_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && in_valid) |=> drop_sticky);

  a_r7_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && rd_en && !in_valid && !clr_req) |=> ##1 rd_valid);

  a_r8_clear_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && clr_req) |=> (busy && (drop_sticky == $past(in_valid))));
endmodule

bind det_map_rmw det_map_rmw_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .clr_req(clr_req),
  .rd_en(rd_en), .busy(busy), .rd_valid(rd_valid),
  .drop_cnt(drop_cnt), .drop_sticky(drop_sticky)
);

// File: tb/sim_det_map_rmw.sv
module sim_det_map_rmw;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_flag = 1'b0, clr_req = 1'b0, rd_en = 1'b0;
  logic [8:0]  in_range = '0, rd_addr = '0;
  logic [4:0]  in_dop = '0;
  logic [31:0] rd_data;
  logic        rd_valid, busy, drop_sticky;
  logic [15:0] drop_cnt;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  det_map_rmw u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_flag(in_flag),
    .in_range(in_range), .in_dop(in_dop), .clr_req(clr_req), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy),
    .drop_cnt(drop_cnt), .drop_sticky(drop_sticky)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [8:0] r, input logic [4:0] d, input logic f);
    in_valid = 1'b1; in_range = r; in_dop = d; in_flag = f;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic host_rd(input logic [8:0] a, output logic [31:0] w);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    chk(rd_valid == 1'b0, "R7 early", 32'(rd_valid), 0);
    @(negedge clk);
    chk(rd_valid == 1'b1, "R7 valid", 32'(rd_valid), 1);
    w = rd_data;
  endtask

  task automatic t_reset();
    chk(busy == 0 && drop_cnt == 0 && drop_sticky == 0 && rd_valid == 0, "R9 reset", {busy, drop_sticky, drop_cnt}, 0);
  endtask

  task automatic t_set_clear_bits();
    logic [31:0] w;
    send(9'd5, 5'd3, 1'b1); @(negedge clk); @(negedge clk);
    host_rd(9'd5, w);
    chk(w == 32'h8, "R3 bit placement", w, 32'h8);
    send(9'd5, 5'd7, 1'b1); @(negedge clk); @(negedge clk);
    host_rd(9'd5, w);
    chk(w == 32'h88, "R4 keep other bits", w, 32'h88);
    send(9'd5, 5'd3, 1'b0); @(negedge clk); @(negedge clk);
    host_rd(9'd5, w);
    chk(w == 32'h80, "R4 clear bit", w, 32'h80);
    send(9'd300, 5'd31, 1'b1); @(negedge clk); @(negedge clk);
    host_rd(9'd300, w);
    chk(w == 32'h8000_0000, "R3 top bit", w, 32'h8000_0000);
  endtask

  task automatic t_busy_seq();
    in_valid = 1'b1; in_range = 9'd9; in_dop = 5'd0; in_flag = 1'b1;
    @(negedge clk); in_valid = 1'b0;
    chk(busy == 1, "R1 busy cycle1", 32'(busy), 1);
    @(negedge clk);
    chk(busy == 1, "R1 busy cycle2", 32'(busy), 1);
    @(negedge clk);
    chk(busy == 0, "R1 idle cycle3", 32'(busy), 0);
  endtask

  task automatic t_cadence();
    logic [31:0] w;
    logic [15:0] c0 = drop_cnt;
    for (int i = 0; i < 4; i++) begin
      send(9'd20, 5'(i * 2), 1'b1); @(negedge clk); @(negedge clk);
    end
    chk(drop_cnt == c0, "R5 no drops", 32'(drop_cnt), 32'(c0));
    host_rd(9'd20, w);
    chk(w == 32'h55, "R5 all applied", w, 32'h55);
  endtask

  task automatic t_drop();
    logic [31:0] w;
    logic [15:0] c0 = drop_cnt;
    in_valid = 1'b1; in_range = 9'd40; in_dop = 5'd1; in_flag = 1'b1;
    @(negedge clk);
    in_range = 9'd41; in_dop = 5'd2;
    @(negedge clk); in_valid = 1'b0;
    chk(drop_cnt == c0 + 1, "R6 count", 32'(drop_cnt), 32'(c0 + 1));
    chk(drop_sticky == 1, "R6 sticky", 32'(drop_sticky), 1);
    @(negedge clk);
    host_rd(9'd41, w);
    chk(w == 0, "R2 map unchanged", w, 0);
    host_rd(9'd40, w);
    chk(w == 32'h2, "R2 first applied", w, 32'h2);
  endtask

  task automatic t_clear();
    logic [31:0] w;
    int n = 0;
    logic [15:0] c0 = drop_cnt;
    clr_req = 1'b1; @(negedge clk); clr_req = 1'b0;
    chk(drop_sticky == 0, "R8 sticky cleared", 32'(drop_sticky), 0);
    while (busy && n < 600) begin
      n++;
      if (n == 100) begin in_valid = 1'b1; in_range = 9'd7; in_dop = 5'd7; in_flag = 1'b1; end
      if (n == 101) in_valid = 1'b0;
      @(negedge clk);
    end
    chk(n == 512, "R8 busy length", n, 512);
    chk(drop_cnt == c0 + 1, "R8 drop during clear", 32'(drop_cnt), 32'(c0 + 1));
    host_rd(9'd5, w);   chk(w == 0, "R8 word 5 zero", w, 0);
    host_rd(9'd20, w);  chk(w == 0, "R8 word 20 zero", w, 0);
    host_rd(9'd7, w);   chk(w == 0, "R8 word 7 zero", w, 0);
    host_rd(9'd300, w); chk(w == 0, "R8 word 300 zero", w, 0);
  endtask

  task automatic t_saturate();
    in_valid = 1'b1; clr_req = 1'b1;
    for (int i = 0; i < 65600; i++) @(negedge clk);
    chk(drop_cnt == 16'hFFFF, "R6 saturate", 32'(drop_cnt), 32'hFFFF);
    @(negedge clk);
    chk(drop_cnt == 16'hFFFF, "R6 hold", 32'(drop_cnt), 32'hFFFF);
    in_valid = 1'b0; clr_req = 1'b0;
  endtask

  task automatic t_async_reset();
    clr_req = 1'b1; @(negedge clk); clr_req = 1'b0;
    @(negedge clk);
    rst_n = 1'b0; #1;
    chk(busy == 0 && drop_cnt == 0 && drop_sticky == 0, "R9 async reset", {busy, drop_sticky, drop_cnt}, 0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_set_clear_bits();
    t_busy_seq();
    t_cadence();
    t_drop();
    t_clear();
    t_saturate();
    t_async_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule